// File: doc/BRIEF.md
# Receive Cut-Through Drain Gate

This block sits on the read side of a receive byte FIFO and decides when the downstream reader may begin draining a frame. It watches the write-side strobes, counts the bytes of the frame currently being stored, and compares that count with a programmable 16-bit start threshold. When enough of the frame is buffered, the reader is released, so frames move through with low latency. A frame that ends before it reaches the threshold is released once its last byte is stored, which gives store-and-forward behaviour for short frames.

The threshold is loaded through two 8-bit register halves. After reset it is 420 bytes. Typical settings are 20 bytes for generic-framing traffic and 1150 bytes for link-access traffic that carries jumbo frames. A new value takes effect only at a frame boundary, so a frame in flight is never judged against two different thresholds. The permission output `rd_ok` only gates the start of frames. The FIFO's own empty flag must still guard each individual byte read. The storage array is outside this block.

Top module: `frame_drain_gate`

## Requirements
- R1: After reset the programmed and active threshold is 420 (0x01A4), `rd_ok` is low and `frm_bytes` is 0.
- R2: A register write with `cfg_hi`=0 loads `cfg_data` into threshold bits 7:0, and one with `cfg_hi`=1 loads it into bits 15:8. The other half is unchanged.
- R3: `frm_bytes` rises by one in the cycle after each stored byte that is not an end-of-frame byte. It is 0 in the cycle after an end-of-frame byte is stored.
- R4: `rd_ok` goes high in the cycle after the write that brings the current frame's stored count to a value greater than or equal to the active threshold.
- R5: A frame that ends below the threshold makes `rd_ok` high in the cycle after its end-of-frame byte is stored.
- R6: Once a frame has been started, `rd_ok` stays high until that frame's end-of-frame byte is read (`rd_en` and `rd_eof` with `rd_ok` high).
- R7: With a threshold of 0, `rd_ok` goes high in the cycle after the first byte of a frame is stored.
- R8: `frm_bytes` saturates at 0xFFFF while further non-final bytes are stored.
- R9: The active threshold is captured from the programmed value while the current frame has no stored bytes. A write made during a frame applies from the next frame.
- R10: Each fully stored frame that is not yet read is remembered. After one frame's end-of-frame byte is read, `rd_ok` stays high if another complete frame is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Threshold register write strobe |
| cfg_hi | input | 1 | Selects the threshold half: 0 for bits 7:0, 1 for bits 15:8 |
| cfg_data | input | 8 | Threshold half value |
| wr_en | input | 1 | A byte is stored into the FIFO this cycle |
| wr_eof | input | 1 | The stored byte ends its frame |
| rd_en | input | 1 | The downstream reader takes a byte this cycle |
| rd_eof | input | 1 | The byte being read ends its frame |
| rd_ok | output | 1 | The reader may start or continue draining the head frame |
| frm_bytes | output | 16 | Stored byte count of the frame currently being written |

## Verification
Several properties are checked on every cycle by assertions. These cover the counter stepping, clearing and saturating, permission being held across a started frame, an end-of-frame write always releasing the reader, the active threshold staying frozen while a frame has bytes stored, and permission continuing when complete frames remain queued. Other behaviours can only be shown by the bench's scenarios against its reference model. These are the exact cycle in which the threshold is crossed, the reset value of 420, the placement of each register half, the zero-threshold case, and the deferral of a threshold written in the middle of a frame.

// File: rtl/frame_drain_gate.sv
module frame_drain_gate #(
  parameter int CFG_W = 8,
  parameter int PEND_W = 6,
  parameter logic [2*CFG_W-1:0] RST_THR = 'h01A4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              cfg_hi,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic              wr_en,
  input  logic              wr_eof,
  input  logic              rd_en,
  input  logic              rd_eof,
  output logic              rd_ok,
  output logic [2*CFG_W-1:0] frm_bytes
);
  localparam int CNT_W = 2 * CFG_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = 1;
  localparam logic [PEND_W-1:0] PEND_ONE = 1;

  logic [CNT_W-1:0]  thr_prog, thr_act, cnt_q;
  logic [PEND_W-1:0] pend_q;
  logic              pend_inc, pend_dec, thr_met;

  assign pend_inc  = wr_en & wr_eof;
  assign pend_dec  = rd_en & rd_ok & rd_eof;
  assign thr_met   = (cnt_q != '0) && (cnt_q >= thr_act);
  assign rd_ok     = (pend_q != '0) | thr_met;
  assign frm_bytes = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_prog <= RST_THR;
    end else if (cfg_wr) begin
      if (cfg_hi) thr_prog[CNT_W-1:CFG_W] <= cfg_data;
      else        thr_prog[CFG_W-1:0]     <= cfg_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              thr_act <= RST_THR;
    else if (cnt_q == '0)    thr_act <= thr_prog;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (wr_en && wr_eof)      cnt_q <= '0;
    else if (wr_en && cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     pend_q <= '0;
    else if (pend_inc && !pend_dec) pend_q <= pend_q + PEND_ONE;
    else if (!pend_inc && pend_dec) pend_q <= pend_q - PEND_ONE;
  end

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_eof && cnt_q != CNT_MAX) |=> frm_bytes == $past(frm_bytes) + CNT_ONE);
  a_r3_eof_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_eof) |=> frm_bytes == '0);
  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_eof && cnt_q == CNT_MAX) |=> frm_bytes == CNT_MAX);
  a_r5_eof_release: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_eof) |=> rd_ok);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_ok && !rd_eof) |=> rd_ok);
  a_r9_thr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |=> $stable(thr_act));
  a_r10_queued: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_ok && rd_eof && pend_q > PEND_ONE) |=> rd_ok);
endmodule

// File: tb/test_frame_drain_gate.sv
module test_frame_drain_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, cfg_hi = 0, wr_en = 0, wr_eof = 0, rd_en = 0, rd_eof = 0;
  logic [7:0] cfg_data = 0;
  logic rd_ok;
  logic [15:0] frm_bytes;

  int n_vec = 0, n_bad = 0, n_cyc = 0;
  int m_thrp = 420, m_thra = 420, m_cnt = 0, m_pend = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  frame_drain_gate i_frame_drain_gate (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_hi(cfg_hi), .cfg_data(cfg_data),
    .wr_en(wr_en), .wr_eof(wr_eof), .rd_en(rd_en), .rd_eof(rd_eof),
    .rd_ok(rd_ok), .frm_bytes(frm_bytes));

  function automatic bit m_ok();
    return (m_pend > 0) || (m_cnt != 0 && m_cnt >= m_thra);
  endfunction

  task automatic chk(input int act, input int exp, input string what);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit cw, input bit ch, input int cd,
                     input bit we, input bit weof, input bit re, input bit reof);
    bit fire;
    cfg_wr = cw; cfg_hi = ch; cfg_data = cd[7:0];
    wr_en = we; wr_eof = weof; rd_en = re; rd_eof = reof;
    fire = re && m_ok();
    if (m_cnt == 0) m_thra = m_thrp;
    if (cw) m_thrp = ch ? ((m_thrp & 'hFF) | ((cd & 'hFF) << 8)) : ((m_thrp & 'hFF00) | (cd & 'hFF));
    if (we && weof) m_pend++;
    if (fire && reof) m_pend--;
    if (we) m_cnt = weof ? 0 : ((m_cnt < 65535) ? m_cnt + 1 : 65535);
    @(negedge clk);
    chk(int'(rd_ok), int'(m_ok()), "rd_ok");
    chk(int'(frm_bytes), m_cnt, "frm_bytes");
  endtask

  task automatic idle(); cyc(0,0,0,0,0,0,0); endtask
  task automatic set_thr(input int v);
    cyc(1,0,v & 'hFF,0,0,0,0);
    cyc(1,1,(v >> 8) & 'hFF,0,0,0,0);
  endtask
  task automatic wr_n(input int n, input bit eof_last);
    for (int i = 0; i < n; i++) cyc(0,0,0,1,eof_last && (i == n-1),0,0);
  endtask
  task automatic rd_n(input int n);
    for (int i = 0; i < n; i++) cyc(0,0,0,0,0,1,i == n-1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      n_cyc++;
      if (n_cyc > 190000) begin
        n_bad++; n_vec++;
        $display("FAIL watchdog: got %0d cycles expected under 190000", n_cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    chk(int'(rd_ok), 0, "rd_ok after reset");
    chk(int'(frm_bytes), 0, "frm_bytes after reset");
    wr_n(419, 0);
    chk(int'(rd_ok), 0, "default threshold 420 not reached");
    tag = "R4";
    wr_n(1, 0);
    chk(int'(rd_ok), 1, "default threshold 420 reached");
    tag = "R6";
    rd_n(0);
    for (int i = 0; i < 30; i++) cyc(0,0,0,1,i == 29,1,0);
    chk(int'(rd_ok), 1, "still reading started frame");
    rd_n(420);
    chk(int'(rd_ok), 0, "frame done");

    tag = "R2";
    set_thr('h0014);
    idle();
    wr_n(19, 0);
    chk(int'(rd_ok), 0, "low half 20 below");
    tag = "R4";
    wr_n(1, 0);
    chk(int'(rd_ok), 1, "low half 20 reached");
    tag = "R3";
    wr_n(5, 1);
    chk(int'(frm_bytes), 0, "count clear after eof");
    rd_n(25);
    tag = "R2";
    cyc(1,1,'h01,0,0,0,0);
    idle();
    wr_n(275, 0);
    chk(int'(rd_ok), 0, "high half gives 276");
    wr_n(1, 0);
    chk(int'(rd_ok), 1, "276 reached");
    wr_n(1, 1);
    rd_n(277);

    tag = "R5";
    set_thr(1150);
    idle();
    wr_n(4, 0);
    chk(int'(rd_ok), 0, "short frame held");
    wr_n(1, 1);
    chk(int'(rd_ok), 1, "short frame released on eof");
    tag = "R10";
    wr_n(3, 1);
    rd_n(5);
    chk(int'(rd_ok), 1, "second frame queued");
    rd_n(3);
    chk(int'(rd_ok), 0, "queue empty");

    tag = "R7";
    set_thr(0);
    idle();
    chk(int'(rd_ok), 0, "zero threshold idle");
    wr_n(1, 0);
    chk(int'(rd_ok), 1, "zero threshold first byte");
    wr_n(1, 1);
    rd_n(2);

    tag = "R9";
    set_thr(20);
    idle();
    wr_n(3, 0);
    set_thr(5);
    wr_n(2, 0);
    chk(int'(rd_ok), 0, "mid-frame write deferred");
    wr_n(15, 0);
    chk(int'(rd_ok), 1, "old threshold 20 used");
    wr_n(1, 1);
    rd_n(21);
    wr_n(4, 0);
    chk(int'(rd_ok), 0, "new threshold 5 below");
    wr_n(1, 0);
    chk(int'(rd_ok), 1, "new threshold 5 reached");
    wr_n(1, 1);
    rd_n(6);

    tag = "R8";
    set_thr('hFFFF);
    idle();
    wr_n(65534, 0);
    chk(int'(rd_ok), 0, "below 65535");
    wr_n(1, 0);
    chk(int'(rd_ok), 1, "65535 reached");
    wr_n(3, 0);
    chk(int'(frm_bytes), 65535, "saturated count");
    wr_n(1, 1);
    chk(int'(frm_bytes), 0, "cleared after saturation");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule